// File: doc/BRIEF.md
# Partly Serial Antisymmetric FIR Filter with Reloadable Coefficients

This block is an odd-length antisymmetric FIR filter whose arithmetic is time-shared. The impulse response satisfies h[N-1-k] = -h[k], so the centre tap is zero and only floor(N/2) coefficients are stored. For the default 23 taps that is 11. The stored coefficients are divided into two segments (7 and 4 by default). Each segment owns one multiply-accumulate unit. That unit visits one coefficient per system clock and multiplies it by the difference of the two samples that share it. The system clock runs at P times the sample rate, where P is the longer segment length (7 by default). One sample is accepted every P clocks.

A host loads coefficients at the system clock rate through a write port of data, address, write strobe and a done strobe. Writes land in a staging bank that the datapath never reads. A rising done strobe schedules a swap between the staging bank and the working bank. The swap always happens on a sample boundary. Whether it happens at the very next sample or the one after depends on how many clocks remain before that sample when the done strobe rises. A parameter selects how the store is read: combinationally, like a register file, or through a registered read port, like a synchronous memory.

Top module: `antisym_serial_fir`

## Requirements
- R1: After reset, y_out is 0.
- R2: Samples are presented with smp_valid high for one clock, exactly every P clocks. After the clock edge that accepts sample x[m], y_out holds y[m-2], with y[n] = sum over k=0..10 of c[k]*(x[n-k] - x[n-22+k]). Samples before the first one count as 0, and so does y[n] for negative n. The coefficient set c is the one in use while sample n is processed.
- R3: y_out changes only on a clock edge where smp_valid is high.
- R4: While cf_wr_en is high, cf_wr_data is written at the coefficient index cf_wr_addr (0..10 is c[0]..c[10]) into the staging set. Staged values do not affect any output until a commit.
- R5: A write with cf_wr_addr of 11 or more changes no coefficient.
- R6: Suppose the rising edge of cf_wr_done is sampled at least 2 clocks before the edge that accepts the next sample. That is, it is sampled at the edge that accepts sample s, or at most 5 clocks after it. Then the staged set is used from sample s+1 onward.
- R7: If the rising edge of cf_wr_done is sampled 6 clocks after the edge that accepts sample s, the staged set is first used by sample s+2.
- R8: Holding cf_wr_done high for many clocks causes exactly one commit, taken from its rising edge.
- R9: With no sample in flight, a done rise followed by at least 2 clocks before the next accepted sample makes that sample use the new set.
- R10: After a commit, the staging set holds the set that was in use before the commit. Any index not rewritten before the next commit keeps that older value.
- R11: With REG_READ=1 (registered coefficient read), y_out is identical at every clock to the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, P times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-clock strobe accepting smp_data |
| smp_data | input | 16 | Signed input sample |
| cf_wr_en | input | 1 | Coefficient write strobe |
| cf_wr_addr | input | 4 | Coefficient index to write |
| cf_wr_data | input | 16 | Signed coefficient value |
| cf_wr_done | input | 1 | Rising edge requests a commit of the staged set |
| y_out | output | 37 | Signed filter result, two samples behind the input |

## Verification
A sample accepted at a clock edge sets y_out at that same edge, and y_out then holds y[m-2]. The bench therefore reads it at the falling edge one clock later and reads it again three clocks into the window to confirm it has not moved. Done strobes are placed at window offsets 2, 3, 5 and 6, both as single pulses and as a held level. This makes the expected first-affected sample s+1 or s+2 a pure function of the offset. The output that proves a commit appears two samples after the affected sample, and each check looks there. Both read variants run side by side against the same arithmetic model.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // width of an index able to address n entries (at least 1 bit)
  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int seg_len(input int g, input int len_a, input int len_b);
    return (g == 0) ? len_a : len_b;
  endfunction

  function automatic int seg_base(input int g, input int len_a);
    return (g == 0) ? 0 : len_a;
  endfunction

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int LEN      = 7,
  parameter int CW       = 16,
  parameter int AW       = 3,
  parameter int RW       = 3,
  parameter int REG_READ = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [CW-1:0] wdata,
  input  logic                 wbank,
  input  logic                 rbank,
  input  logic [RW-1:0]        raddr,
  output logic signed [CW-1:0] rdata
);

  logic signed [CW-1:0] mem [2][LEN];
  logic signed [CW-1:0] rd_now;
  logic                 rd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < LEN; i++)
          mem[b][i] <= '0;
    end else if (we) begin
      mem[wbank][waddr] <= wdata;
    end
  end

  // write index is decoded upstream; it must stay inside this segment
  p_wr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < LEN));

  assign rd_ok  = int'(raddr) < LEN;
  assign rd_now = rd_ok ? mem[rbank][AW'(raddr)] : '0;

  generate
    if (REG_READ != 0) begin : g_sync_rd
      always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_now;
      end
    end else begin : g_comb_rd
      assign rdata = rd_now;
    end
  endgenerate

endmodule

// File: rtl/fir_seg_mac.sv
module fir_seg_mac #(
  parameter int PAIRW = 17,
  parameter int CW    = 16,
  parameter int OW    = 37
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [PAIRW-1:0] pair,
  input  logic signed [CW-1:0]    coef,
  output logic signed [OW-1:0]    acc
);

  function automatic logic signed [OW-1:0] mac_next(
    input logic signed [OW-1:0]    a,
    input logic signed [PAIRW-1:0] p,
    input logic signed [CW-1:0]    c,
    input logic                    clr
  );
    logic signed [PAIRW+CW-1:0] prod;
    prod = p * c;
    return (clr ? OW'(0) : a) + OW'(prod);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= mac_next(acc, pair, coef, first);
  end

endmodule

// File: rtl/fir_commit_ctrl.sv
module fir_commit_ctrl #(
  parameter int P  = 7,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_in,
  input  logic          smp_valid,
  input  logic          run,
  input  logic [PW-1:0] ph,
  output logic          bank_sel
);

  logic done_q, pending, armed;
  logic done_rise, arm_evt;

  assign done_rise = done_in && !done_q;
  // decision point: last-but-one phase of a window, or any idle cycle
  assign arm_evt   = pending && (!run || (ph == PW'(P - 2)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      pending  <= 1'b0;
      armed    <= 1'b0;
      bank_sel <= 1'b0;
    end else begin
      done_q <= done_in;
      if (done_rise)    pending <= 1'b1;
      else if (arm_evt) pending <= 1'b0;
      if (arm_evt)        armed <= 1'b1;
      else if (smp_valid) armed <= 1'b0;
      if (smp_valid && armed) bank_sel <= ~bank_sel;
    end
  end

  p_flip_on_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_sel) |-> $past(smp_valid));

  p_flip_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !armed) |=> $stable(bank_sel));

  p_arm_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> (!pending || $past(done_rise)));

endmodule

// File: rtl/antisym_serial_fir.sv
module antisym_serial_fir
  import fir_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int NTAPS    = 23,
  parameter int SEG_A    = 7,
  parameter int SEG_B    = 4,
  parameter int REG_READ = 0
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          smp_valid,
  input  logic signed [DW-1:0]                          smp_data,
  input  logic                                          cf_wr_en,
  input  logic [addr_bits(NTAPS/2)-1:0]                 cf_wr_addr,
  input  logic signed [CW-1:0]                          cf_wr_data,
  input  logic                                          cf_wr_done,
  output logic signed [DW+CW+1+addr_bits(NTAPS/2)-1:0]  y_out
);

  localparam int NC    = NTAPS / 2;
  localparam int NSEG  = 2;
  localparam int P     = (SEG_A > SEG_B) ? SEG_A : SEG_B;
  localparam int PW    = addr_bits(P);
  localparam int AWD   = addr_bits(NC);
  localparam int OW    = DW + CW + 1 + AWD;
  localparam int PAIRW = DW + 1;

  function automatic logic signed [PAIRW-1:0] pair_diff(
    input logic signed [DW-1:0] a,
    input logic signed [DW-1:0] b
  );
    return $signed({a[DW-1], a}) - $signed({b[DW-1], b});
  endfunction

  // ---------------- sample delay line ----------------
  logic signed [DW-1:0] taps [NTAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
    end else if (smp_valid) begin
      taps[0] <= smp_data;
      for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // ---------------- phase sequencer ----------------
  logic [PW-1:0] ph;
  logic          run;
  logic          last0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= '0;
      run <= 1'b0;
    end else if (smp_valid) begin
      ph  <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (ph == PW'(P - 1)) run <= 1'b0;
      else                  ph  <= ph + 1'b1;
    end
  end

  assign last0 = run && (ph == PW'(P - 1));

  p_ph_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) < P);

  p_run_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ph == PW'(P - 1)) && !smp_valid) |=> !run);

  // ---------------- commit control ----------------
  logic bank_sel;

  fir_commit_ctrl #(.P(P), .PW(PW)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_in   (cf_wr_done),
    .smp_valid (smp_valid),
    .run       (run),
    .ph        (ph),
    .bank_sel  (bank_sel)
  );

  // ---------------- segments ----------------
  logic signed [OW-1:0] acc [NSEG];

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam int LEN  = seg_len(g, SEG_A, SEG_B);
      localparam int BASE = seg_base(g, SEG_A);
      localparam int LAW  = addr_bits(LEN);

      logic                    hit;
      logic [LAW-1:0]          lad;
      logic signed [CW-1:0]    coef;
      logic signed [PAIRW-1:0] pair0, pair_e;
      logic                    en0, first0, en_e, first_e;

      assign hit = cf_wr_en && (int'(cf_wr_addr) >= BASE) &&
                   (int'(cf_wr_addr) < BASE + LEN);
      assign lad = LAW'(int'(cf_wr_addr) - BASE);

      fir_coef_bank #(
        .LEN(LEN), .CW(CW), .AW(LAW), .RW(PW), .REG_READ(REG_READ)
      ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hit),
        .waddr (lad),
        .wdata (cf_wr_data),
        .wbank (~bank_sel),
        .rbank (bank_sel),
        .raddr (ph),
        .rdata (coef)
      );

      always_comb begin
        pair0 = '0;
        for (int t = 0; t < LEN; t++)
          if (int'(ph) == t)
            pair0 = pair_diff(taps[BASE + t], taps[NTAPS - 1 - BASE - t]);
      end

      assign en0    = run && (int'(ph) < LEN);
      assign first0 = (ph == '0);

      if (REG_READ != 0) begin : g_pipe
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            en_e    <= 1'b0;
            first_e <= 1'b0;
            pair_e  <= '0;
          end else begin
            en_e    <= en0;
            first_e <= first0;
            pair_e  <= pair0;
          end
        end
      end else begin : g_direct
        assign en_e    = en0;
        assign first_e = first0;
        assign pair_e  = pair0;
      end

      fir_seg_mac #(.PAIRW(PAIRW), .CW(CW), .OW(OW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_e),
        .first (first_e),
        .pair  (pair_e),
        .coef  (coef),
        .acc   (acc[g])
      );
    end
  endgenerate

  // ---------------- final sum and output ----------------
  logic                 last_e, fin;
  logic signed [OW-1:0] sum_all, sum_reg;

  generate
    if (REG_READ != 0) begin : g_last_pipe
      always_ff @(posedge clk) begin
        if (!rst_n) last_e <= 1'b0;
        else        last_e <= last0;
      end
    end else begin : g_last_direct
      assign last_e = last0;
    end
  endgenerate

  always_comb begin
    sum_all = '0;
    for (int g = 0; g < NSEG; g++) sum_all = sum_all + acc[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin     <= 1'b0;
      sum_reg <= '0;
      y_out   <= '0;
    end else begin
      fin <= last_e;
      if (fin)       sum_reg <= sum_all;
      if (smp_valid) y_out   <= sum_reg;
    end
  end

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_out) |-> $past(smp_valid));

endmodule

// File: tb/test_antisym_serial_fir.sv
module test_antisym_serial_fir;

  localparam int NS  = 48;
  localparam int NC  = 11;
  localparam int NT  = 23;
  localparam int P   = 7;
  localparam int OW  = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_data = '0;
  logic cf_wr_en = 1'b0;
  logic [3:0] cf_wr_addr = '0;
  logic signed [15:0] cf_wr_data = '0;
  logic cf_wr_done = 1'b0;
  logic signed [OW-1:0] y_a, y_b;

  always #4 clk = ~clk;

  antisym_serial_fir i_antisym_serial_fir (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cf_wr_en(cf_wr_en), .cf_wr_addr(cf_wr_addr), .cf_wr_data(cf_wr_data),
    .cf_wr_done(cf_wr_done), .y_out(y_a));

  antisym_serial_fir #(.REG_READ(1)) i_antisym_serial_fir_rr (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cf_wr_en(cf_wr_en), .cf_wr_addr(cf_wr_addr), .cf_wr_data(cf_wr_data),
    .cf_wr_done(cf_wr_done), .y_out(y_b));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  longint xs [NS];
  longint cs [5][NC];
  longint held_a, held_b;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint cval(input int k, input int i);
    if (i == k)     return 32767;
    if (i == k + 5) return -32768;
    return ((k * 7 + 1) * (i * 2311 + 977)) % 65536 - 32768;
  endfunction

  function automatic longint xval(input int s);
    if (s % 9 == 4) return 32767;
    if (s % 9 == 7) return -32768;
    return (s * 4099 + 321) % 65536 - 32768;
  endfunction

  // which coefficient set processes sample n (from R6..R10 and the schedule)
  function automatic int set_of(input int n);
    if (n < 10) return 0;   // R9 preload, R6 commit at (9,5)
    if (n < 19) return 1;   // R7 late commit at (17,6)
    if (n < 28) return 2;   // R8 held done from (27,2)
    if (n < 37) return 3;   // R10 partial set committed at (36,3)
    return 4;
  endfunction

  function automatic longint exp_y(input int n);
    longint acc = 0;
    if (n < 0) return 0;
    for (int k = 0; k < NC; k++) begin
      longint xa = (n - k >= 0) ? xs[n - k] : 0;
      longint xb = (n - (NT - 1) + k >= 0) ? xs[n - (NT - 1) + k] : 0;
      acc += cs[set_of(n)][k] * (xa - xb);
    end
    return acc;
  endfunction

  function automatic string tag_of(input int n);
    if (n < 8)             return "R9";
    if (n == 9)            return "R4";
    if (n == 10)           return "R6";
    if (n == 18 || n == 19) return "R7";
    if (n >= 27 && n < 36) return "R8";
    if (n == 36)           return "R6";
    if (n >= 37)           return "R10/R5";
    return "R2";
  endfunction

  task automatic drive_writes(input int gc);
    cf_wr_en   = 1'b0;
    cf_wr_addr = '0;
    cf_wr_data = '0;
    if (gc >= 8*P && gc < 8*P + NC) begin
      cf_wr_en = 1'b1; cf_wr_addr = 4'(gc - 8*P);
      cf_wr_data = 16'(cs[1][gc - 8*P]);
    end else if (gc >= 16*P && gc < 16*P + NC) begin
      cf_wr_en = 1'b1; cf_wr_addr = 4'(gc - 16*P);
      cf_wr_data = 16'(cs[2][gc - 16*P]);
    end else if (gc >= 26*P && gc < 26*P + NC) begin
      cf_wr_en = 1'b1; cf_wr_addr = 4'(gc - 26*P);
      cf_wr_data = 16'(cs[3][gc - 26*P]);
    end else if (gc == 36*P) begin
      cf_wr_en = 1'b1; cf_wr_addr = 4'd0; cf_wr_data = 16'(cs[4][0]);
    end else if (gc == 36*P + 1) begin
      cf_wr_en = 1'b1; cf_wr_addr = 4'd11; cf_wr_data = 16'sd999;   // R5
    end else if (gc == 36*P + 2) begin
      cf_wr_en = 1'b1; cf_wr_addr = 4'd15; cf_wr_data = -16'sd7;    // R5
    end
    cf_wr_done = (gc == 9*P + 5) || (gc == 17*P + 6) ||
                 (gc >= 27*P + 2 && gc < 27*P + 22) || (gc == 36*P + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) xs[s] = xval(s);
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < NC; i++) cs[k][i] = cval(k, i);
    for (int i = 0; i < NC; i++) cs[4][i] = cs[2][i];   // R10 older set
    cs[4][0] = 12345;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", y_a, 0);
    chk("R11 reset", y_b, 0);

    // idle preload of set 0, done, then two quiet clocks (R9)
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      cf_wr_en   = (i < NC);
      cf_wr_addr = 4'(i);
      cf_wr_data = (i < NC) ? 16'(cs[0][i]) : '0;
      cf_wr_done = (i == 11);
    end

    for (int s = 0; s < NS; s++) begin
      for (int q = 0; q < P; q++) begin
        @(negedge clk);
        if (q == 1) begin
          chk($sformatf("%s y[%0d]", tag_of(s - 2), s - 2), y_a, exp_y(s - 2));
          chk($sformatf("R11 %s y[%0d]", tag_of(s - 2), s - 2), y_b, exp_y(s - 2));
          held_a = y_a;
          held_b = y_b;
        end
        if (q == 4 && s % 4 == 0) begin
          chk($sformatf("R3 hold s%0d", s), y_a, held_a);
          chk($sformatf("R3 R11 hold s%0d", s), y_b, held_b);
        end
        smp_valid = (q == 0);
        smp_data  = (q == 0) ? 16'(xs[s]) : '0;
        drive_writes(s * P + q);
      end
    end

    @(negedge clk);
    smp_valid = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule